// File: doc/BRIEF.md
# Bus Status Command Decoder

This block sits beside a processor running in a multi-master configuration. The processor does not drive separate read and write strobes. Instead it puts out a three-bit status code that changes over time. The decoder watches that code and rebuilds the individual bus commands from it: memory read, memory write, I/O read, I/O write and interrupt acknowledge. It also produces the address latch pulse, the data buffer enable and the transfer direction.

A bus cycle begins when the status code leaves the passive value 111. On the next clock the decoder latches the code and pulses the address latch. On the clock after that it raises the command strobe that matches the latched code. The strobe stays up until the status returns to passive. A change from one active code to another active code does not start a new cycle.

The command strobes and the buffer enable can be built active-high or active-low through one parameter. The address latch pulse is always active-high.

Top module: `bus_stat_cmd_dec`

## Requirements
- R1: While reset is asserted and on the first sample after it, ALE, DEN, DT/R and all five command strobes are inactive.
- R2: ALE is high for exactly one clock. That clock is the one after the first edge that samples a code other than 111 when the previous sampled code was 111.
- R3: Codes 100 (code fetch) and 101 (memory read) raise the memory read strobe from the clock after ALE. The strobe falls on the clock after the edge that samples 111.
- R4: Code 110 raises the memory write strobe with the same timing as R3.
- R5: Code 001 raises the I/O read strobe and code 010 raises the I/O write strobe, with the same timing as R3.
- R6: Code 000 raises the interrupt acknowledge strobe, with the same timing as R3.
- R7: Code 011 (halt) pulses ALE but raises no command strobe and no DEN.
- R8: At most one command strobe is active at a time, and none is active outside a bus cycle.
- R9: DT/R is high from the ALE clock to the end of the cycle for codes 010 and 110. It is low for every other code and while idle.
- R10: DEN is active exactly when a command strobe is active.
- R11: If the status moves from one active code straight to another, no ALE is produced and the strobe of the first code stays active.
- R12: If the status returns to 111 during the ALE clock, no command strobe is raised for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the status code is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_stat | input | 3 | Encoded processor bus status; 111 means passive |
| ale | output | 1 | Address latch pulse, active high |
| den | output | 1 | Data buffer enable |
| dt_r | output | 1 | Transfer direction: 1 means write (transmit), 0 means read (receive) |
| mem_rd | output | 1 | Memory read command strobe (also used for code fetch) |
| mem_wr | output | 1 | Memory write command strobe |
| io_rd | output | 1 | I/O read command strobe |
| io_wr | output | 1 | I/O write command strobe |
| int_ack | output | 1 | Interrupt acknowledge command strobe |

## Verification
Some properties are checked by the assertions on every cycle: a start of cycle is always followed by a single-clock ALE, a strobe only rises after ALE and falls one clock after passive is seen, there is never more than one strobe, DEN tracks the strobes, write strobes carry the write direction, and halt raises nothing. Other behaviour can only be shown by the bench's scenarios. These cover the mapping of each of the eight codes to its particular strobe, the exact clock on which each output changes, a status that hops between active codes in mid-cycle, a cycle that returns to passive during the ALE clock, and the reset state.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

   typedef enum logic [2:0] {
      ST_INTA  = 3'b000,
      ST_IORD  = 3'b001,
      ST_IOWR  = 3'b010,
      ST_HALT  = 3'b011,
      ST_FETCH = 3'b100,
      ST_MRD   = 3'b101,
      ST_MWR   = 3'b110,
      ST_PASS  = 3'b111
   } bstat_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_CMD  = 2'd2
   } phase_e;

   typedef struct packed {
      logic mrd;
      logic mwr;
      logic iord;
      logic iowr;
      logic inta;
   } cmd_t;

   localparam int CMD_COUNT = $bits(cmd_t);

endpackage

// File: rtl/bsc_stat_track.sv
module bsc_stat_track #(
   parameter int                STAT_W    = 3,
   parameter logic [STAT_W-1:0] PASS_CODE = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] stat_i,
   output logic [STAT_W-1:0] prev_o,
   output logic              start_o
);

   logic [STAT_W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= PASS_CODE;
      else        prev_q <= stat_i;
   end

   assign prev_o  = prev_q;
   assign start_o = (prev_q == PASS_CODE) && (stat_i != PASS_CODE);

endmodule

// File: rtl/bsc_cycle_fsm.sv
module bsc_cycle_fsm
   import bsc_pkg::*;
#(
   parameter int                STAT_W    = 3,
   parameter logic [STAT_W-1:0] PASS_CODE = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] stat_i,
   input  logic              start_i,
   output phase_e            phase_o,
   output logic [STAT_W-1:0] code_o,
   output logic              ale_o
);

   phase_e            phase_q, phase_d;
   logic [STAT_W-1:0] code_q;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE: if (start_i)               phase_d = PH_ADDR;
         PH_ADDR: phase_d = (stat_i == PASS_CODE) ? PH_IDLE : PH_CMD;
         PH_CMD:  if (stat_i == PASS_CODE)   phase_d = PH_IDLE;
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         code_q  <= PASS_CODE;
      end else begin
         phase_q <= phase_d;
         if (phase_q == PH_IDLE && start_i) code_q <= stat_i;
      end
   end

   assign phase_o = phase_q;
   assign code_o  = code_q;
   assign ale_o   = (phase_q == PH_ADDR);

   AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ale_o |=> !ale_o) else $error("ALE longer than one clock"); // R2

   AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_IDLE && phase_d != PH_IDLE) |=> $stable(code_q))
      else $error("latched code changed mid-cycle"); // R11

endmodule

// File: rtl/bsc_cmd_decode.sv
module bsc_cmd_decode
   import bsc_pkg::*;
#(
   parameter int STAT_W = 3
) (
   input  phase_e            phase_i,
   input  logic [STAT_W-1:0] code_i,
   output cmd_t              cmd_o,
   output logic              den_o,
   output logic              dtr_o
);

   if (STAT_W != 3) begin : g_bad_width
      $error("bsc_cmd_decode: status width must be 3");
   end

   cmd_t base;
   logic is_write;

   always_comb begin
      base = '0;
      unique case (bstat_e'(code_i))
         ST_INTA:         base.inta = 1'b1;
         ST_IORD:         base.iord = 1'b1;
         ST_IOWR:         base.iowr = 1'b1;
         ST_FETCH, ST_MRD: base.mrd = 1'b1;
         ST_MWR:          base.mwr  = 1'b1;
         default:         base      = '0;
      endcase
   end

   assign is_write = (bstat_e'(code_i) == ST_IOWR) || (bstat_e'(code_i) == ST_MWR);
   assign cmd_o    = (phase_i == PH_CMD) ? base : '0;
   assign den_o    = (phase_i == PH_CMD) && (bstat_e'(code_i) != ST_HALT);
   assign dtr_o    = (phase_i != PH_IDLE) && is_write;

endmodule

// File: rtl/bus_stat_cmd_dec.sv
module bus_stat_cmd_dec
   import bsc_pkg::*;
#(
   parameter int STAT_W      = 3,
   parameter bit CMD_ACT_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] bus_stat,
   output logic              ale,
   output logic              den,
   output logic              dt_r,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              io_rd,
   output logic              io_wr,
   output logic              int_ack
);

   localparam logic [STAT_W-1:0] PASS_CODE = '1;

   if (STAT_W != 3) begin : g_bad_width
      $error("bus_stat_cmd_dec: STAT_W must be 3");
   end
   if (CMD_COUNT != 5) begin : g_bad_cmd
      $error("bus_stat_cmd_dec: command set must hold five strobes");
   end

   logic [STAT_W-1:0] prev;
   logic              start;
   phase_e            phase;
   logic [STAT_W-1:0] code;
   logic              ale_i, den_i, dtr_i;
   cmd_t              cmd;

   bsc_stat_track #(.STAT_W(STAT_W), .PASS_CODE(PASS_CODE)) u_track (
      .clk(clk), .rst_n(rst_n), .stat_i(bus_stat), .prev_o(prev), .start_o(start)
   );

   bsc_cycle_fsm #(.STAT_W(STAT_W), .PASS_CODE(PASS_CODE)) u_fsm (
      .clk(clk), .rst_n(rst_n), .stat_i(bus_stat), .start_i(start),
      .phase_o(phase), .code_o(code), .ale_o(ale_i)
   );

   bsc_cmd_decode #(.STAT_W(STAT_W)) u_dec (
      .phase_i(phase), .code_i(code), .cmd_o(cmd), .den_o(den_i), .dtr_o(dtr_i)
   );

   assign ale  = ale_i;
   assign dt_r = dtr_i;

   if (CMD_ACT_LOW) begin : g_low
      assign den     = ~den_i;
      assign mem_rd  = ~cmd.mrd;
      assign mem_wr  = ~cmd.mwr;
      assign io_rd   = ~cmd.iord;
      assign io_wr   = ~cmd.iowr;
      assign int_ack = ~cmd.inta;
   end else begin : g_high
      assign den     = den_i;
      assign mem_rd  = cmd.mrd;
      assign mem_wr  = cmd.mwr;
      assign io_rd   = cmd.iord;
      assign io_wr   = cmd.iowr;
      assign int_ack = cmd.inta;
   end

   AST_START_GIVES_ALE: assert property (@(posedge clk) disable iff (!rst_n)
      (prev == PASS_CODE && bus_stat != PASS_CODE) |=> ale_i)
      else $error("cycle start without ALE"); // R2

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd)) else $error("several strobes at once"); // R8

   AST_STROBE_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|cmd) |-> $past(ale_i)) else $error("strobe without ALE"); // R3

   AST_PASSIVE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      ((|cmd) && bus_stat == PASS_CODE) |=> !(|cmd))
      else $error("strobe outlived passive status"); // R3

   AST_DEN_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (|cmd) == den_i) else $error("DEN out of step with strobes"); // R10

   AST_WRITE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.mwr || cmd.iowr) |-> dtr_i) else $error("write without DT/R"); // R9

   AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_CMD && code == 3'b011) |-> (cmd == '0 && !den_i))
      else $error("halt raised a strobe"); // R7

endmodule

// File: tb/tb_bus_stat_cmd_dec.sv
`timescale 1ns/1ps
module tb_bus_stat_cmd_dec;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_stat = 3'b111;
   logic ale, den, dt_r, mem_rd, mem_wr, io_rd, io_wr, int_ack;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   bus_stat_cmd_dec dut (
      .clk(clk), .rst_n(rst_n), .bus_stat(bus_stat),
      .ale(ale), .den(den), .dt_r(dt_r), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .io_rd(io_rd), .io_wr(io_wr), .int_ack(int_ack)
   );

   // strobe order {mem_rd, mem_wr, io_rd, io_wr, int_ack}
   function automatic logic [4:0] exp_cmd(input logic [2:0] c);
      case (c)
         3'b000:         return 5'b00001;
         3'b001:         return 5'b00100;
         3'b010:         return 5'b00010;
         3'b100, 3'b101: return 5'b10000;
         3'b110:         return 5'b01000;
         default:        return 5'b00000;
      endcase
   endfunction

   function automatic logic exp_dir(input logic [2:0] c);
      return (c == 3'b010) || (c == 3'b110);
   endfunction

   // vector {ale, den, dt_r, strobes[4:0]}
   task automatic check(input string tag, input logic [7:0] exp);
      logic [7:0] act;
      act = {ale, den, dt_r, mem_rd, mem_wr, io_rd, io_wr, int_ack};
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   // one full cycle; n_cmd command clocks
   task automatic run_cycle(input string tag, input logic [2:0] c, input int n_cmd);
      logic [4:0] s;
      logic       d;
      s = exp_cmd(c);
      d = exp_dir(c);
      @(negedge clk);
      check({tag, " idle before"}, 8'h00);
      bus_stat = c;
      @(negedge clk);
      check({tag, " ALE clock R2"}, {1'b1, 1'b0, d, 5'b0});
      for (int i = 0; i < n_cmd; i++) begin
         @(negedge clk);
         check({tag, " command R10 R9"}, {1'b0, |s, d, s});
      end
      bus_stat = 3'b111;
      @(negedge clk);
      check({tag, " end R8"}, 8'h00);
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1 in reset", 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", 8'h00);
   endtask

   task automatic t_codes;
      run_cycle("R3 memory read 101", 3'b101, 3);
      run_cycle("R3 code fetch 100", 3'b100, 2);
      run_cycle("R4 memory write 110", 3'b110, 2);
      run_cycle("R5 io read 001", 3'b001, 1);
      run_cycle("R5 io write 010", 3'b010, 4);
      run_cycle("R6 int ack 000", 3'b000, 2);
      run_cycle("R7 halt 011", 3'b011, 3);
   endtask

   task automatic t_hop;
      @(negedge clk);
      bus_stat = 3'b101;
      @(negedge clk);
      check("R11 ALE", 8'b1000_0000);
      @(negedge clk);
      check("R11 read strobe", 8'b0101_0000);
      bus_stat = 3'b110;
      @(negedge clk);
      check("R11 no new ALE, read kept", 8'b0101_0000);
      @(negedge clk);
      check("R11 read still kept", 8'b0101_0000);
      bus_stat = 3'b111;
      @(negedge clk);
      check("R11 end", 8'h00);
   endtask

   task automatic t_abort;
      @(negedge clk);
      bus_stat = 3'b110;
      @(negedge clk);
      check("R12 ALE with write dir", 8'b1010_0000);
      bus_stat = 3'b111;
      @(negedge clk);
      check("R12 no strobe", 8'h00);
      @(negedge clk);
      check("R12 stays idle", 8'h00);
   endtask

   task automatic t_back_to_back;
      // one passive clock between cycles is enough for a new start
      @(negedge clk);
      bus_stat = 3'b001;
      @(negedge clk);
      check("R2 first ALE", 8'b1000_0000);
      @(negedge clk);
      check("R5 io read", 8'b0100_0100);
      bus_stat = 3'b111;
      @(negedge clk);
      check("R2 passive gap", 8'h00);
      bus_stat = 3'b000;
      @(negedge clk);
      check("R2 second ALE", 8'b1000_0000);
      @(negedge clk);
      check("R6 int ack", 8'b0100_0001);
      bus_stat = 3'b111;
      @(negedge clk);
      check("R8 idle", 8'h00);
   endtask

   initial begin
      t_reset();
      t_codes();
      t_hop();
      t_abort();
      t_back_to_back();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule